// File: doc/BRIEF.md
# Completion-Detecting Ripple-Carry ALU

This block is a 32-bit arithmetic/logic unit whose adder has no carry acceleration of any kind. Each bit position keeps its carry as a pair of rails, one meaning "carry is one" and one meaning "carry is zero". Both rails start empty. Positions whose two operand bits agree settle their carry at once. Positions where the operand bits differ wait and copy the carry from the position below, one position per clock cycle. A completion detector watches every position, and the unit reports done when no carry is still empty. Because of this, an addition takes as many cycles as its longest run of carry-propagating positions needs. For most operands that is a few cycles, and only the pathological case waits for a carry that ripples across the whole word.

The unit offers move, AND, OR, XOR and add. Before the operation, each input bus can be passed, inverted, forced to zero or forced to all ones. Those modifiers give subtraction (invert B, carry-in one), a plain pass of A, and a constant zero result. Work starts on a one-cycle request. A one-cycle done pulse marks the point where the result, carry-out and zero flag are valid. The outputs then stay unchanged until the next accepted request.

Top module: `rc_alu`

## Requirements
- R1: op_i selects the function: 0 move (result = modified A), 1 AND, 2 OR, 3 XOR, 4 add. Codes 5 to 7 behave as move.
- R2: a_mod_i and b_mod_i each modify their own bus before the operation: 0 pass, 1 bitwise invert, 2 force all zero, 3 force all ones.
- R3: An add produces res_o = A' + B' + cin_i modulo 2^32, and cout_o is the carry out of bit 31.
- R4: A carry never has both rails set. Once a carry has resolved, it keeps its value until the next accepted request.
- R5: For an add, done_o is high in the cycle that lies N+1 cycles after the request cycle, where N is the longest run of adjacent positions with A'[i] != B'[i]. When all 32 positions propagate, this is 33 cycles.
- R6: For move and the logic operations, done_o is high in the cycle right after the request cycle.
- R7: done_o is a single-cycle pulse. res_o, cout_o and zero_o keep their values after done until the next accepted request.
- R8: A request that arrives while an operation is in progress (request accepted, done not yet seen) is ignored. It changes neither the result nor the latency.
- R9: zero_o is 1 exactly when res_o is all zeros. cout_o is 0 for every function other than add.
- R10: After reset, done_o is 0, and res_o reads as zero with zero_o at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Start pulse; accepted only when idle |
| op_i | input | 3 | Function select |
| a_mod_i | input | 2 | Modifier for bus A |
| b_mod_i | input | 2 | Modifier for bus B |
| a_i | input | 32 | Operand bus A |
| b_i | input | 32 | Operand bus B |
| cin_i | input | 1 | Carry into bit 0 for add |
| done_o | output | 1 | One-cycle completion pulse |
| res_o | output | 32 | Result |
| cout_o | output | 1 | Carry out of bit 31 (add only) |
| zero_o | output | 1 | Result is all zeros |

## Verification
Additions are tried with several operand pairs:
- Operands whose bits all agree finish in one cycle; this separates immediate generate/kill settlement from rippling.
- Short propagate runs, such as 5+3, check that the latency follows the longest run and not the operand width.
- All-ones plus one, and all-ones plus zero with carry-in, drive 31-bit and 32-bit ripples; they show that the carry-in enters at bit 0 and that the completion tree waits for the top bit.

Logic operations, move, the undefined codes and each bus modifier are each checked for a one-cycle latency and for the correct value. A subtraction built from invert plus carry-in ties the modifiers and the add together. A request sent in the middle of a long add must leave both the result and the 33-cycle latency unchanged.

// File: rtl/rc_alu_pkg.sv
package rc_alu_pkg;

    localparam int ALU_W = 32;

    typedef enum logic [2:0] {
        OP_MOVE = 3'd0,
        OP_AND  = 3'd1,
        OP_OR   = 3'd2,
        OP_XOR  = 3'd3,
        OP_ADD  = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        MOD_PASS = 2'd0,
        MOD_INV  = 2'd1,
        MOD_ZERO = 2'd2,
        MOD_ONES = 2'd3
    } bus_mod_e;

    // dual-rail carry: t = carry is one, f = carry is zero, both low = not yet known
    typedef struct packed {
        logic t;
        logic f;
    } dr_bit_t;

    function automatic logic dr_known(dr_bit_t d);
        return d.t | d.f;
    endfunction

    function automatic alu_op_e decode_op(logic [2:0] code);
        return (code <= 3'd4) ? alu_op_e'(code) : OP_MOVE;
    endfunction

endpackage

// File: rtl/rc_operand_mod.sv
module rc_operand_mod
    import rc_alu_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  logic [1:0]   mode_i,
    input  logic [W-1:0] bus_i,
    output logic [W-1:0] bus_o
);

    always_comb begin
        unique case (bus_mod_e'(mode_i))
            MOD_PASS: bus_o = bus_i;
            MOD_INV:  bus_o = ~bus_i;
            MOD_ZERO: bus_o = '0;
            MOD_ONES: bus_o = '1;
            default:  bus_o = bus_i;
        endcase
    end

endmodule

// File: rtl/rc_carry_chain.sv
module rc_carry_chain
    import rc_alu_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         arith_i,
    input  logic [W-1:0] new_a_i,
    input  logic [W-1:0] new_b_i,
    input  logic [W-1:0] held_a_i,
    input  logic [W-1:0] held_b_i,
    input  logic         held_cin_i,
    output logic [W-1:0] known_o,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    dr_bit_t rails_q [W];
    dr_bit_t below   [W];

    assign below[0] = '{t: held_cin_i, f: ~held_cin_i};

    genvar gi;
    generate
        for (gi = 1; gi < W; gi++) begin : g_link
            assign below[gi] = rails_q[gi-1];
        end

        for (gi = 0; gi < W; gi++) begin : g_bit
            logic prop;
            assign prop = held_a_i[gi] ^ held_b_i[gi];

            always_ff @(posedge clk) begin
                if (rst) begin
                    rails_q[gi] <= '{t: 1'b0, f: 1'b0};
                end else if (load_i) begin
                    if (arith_i)
                        rails_q[gi] <= '{t: new_a_i[gi] & new_b_i[gi],
                                         f: ~new_a_i[gi] & ~new_b_i[gi]};
                    else
                        rails_q[gi] <= '{t: 1'b0, f: 1'b1};
                end else if (!dr_known(rails_q[gi]) && prop) begin
                    rails_q[gi] <= below[gi];
                end
            end

            assign known_o[gi] = dr_known(rails_q[gi]);
            assign sum_o[gi]   = prop ^ below[gi].t;

            assert_rails_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
                !(rails_q[gi].t && rails_q[gi].f));
            assert_true_sticky_R4: assert property (@(posedge clk) disable iff (rst)
                (!load_i && rails_q[gi].t) |=> rails_q[gi].t);
            assert_false_sticky_R4: assert property (@(posedge clk) disable iff (rst)
                (!load_i && rails_q[gi].f) |=> rails_q[gi].f);
        end
    endgenerate

    assign cout_o = rails_q[W-1].t;

endmodule

// File: rtl/rc_completion.sv
module rc_completion #(
    parameter int W = 32
) (
    input  logic [W-1:0] known_i,
    output logic         all_o
);

    // pairwise reduction tree over the per-bit known flags
    localparam int LEAVES = 1 << $clog2(W);
    logic [2*LEAVES-2:0] node;

    genvar gi;
    generate
        for (gi = 0; gi < LEAVES; gi++) begin : g_leaf
            if (gi < W) begin : g_real
                assign node[LEAVES-1+gi] = known_i[gi];
            end else begin : g_pad
                assign node[LEAVES-1+gi] = 1'b1;
            end
        end
        for (gi = 0; gi < LEAVES-1; gi++) begin : g_inner
            assign node[gi] = node[2*gi+1] & node[2*gi+2];
        end
    endgenerate

    assign all_o = node[0];

endmodule

// File: rtl/rc_alu.sv
module rc_alu
    import rc_alu_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_i,
    input  logic [2:0]   op_i,
    input  logic [1:0]   a_mod_i,
    input  logic [1:0]   b_mod_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic         done_o,
    output logic [W-1:0] res_o,
    output logic         cout_o,
    output logic         zero_o
);

    logic [W-1:0] a_m, b_m;
    logic [W-1:0] a_q, b_q;
    logic         cin_q;
    alu_op_e      op_q;
    logic         busy_q;
    logic         accept;
    logic         complete;
    logic [W-1:0] known;
    logic [W-1:0] sum;
    logic         chain_cout;
    alu_op_e      op_d;

    assign op_d   = decode_op(op_i);
    assign accept = req_i & ~busy_q;

    rc_operand_mod #(.W(W)) u_mod_a (.mode_i(a_mod_i), .bus_i(a_i), .bus_o(a_m));
    rc_operand_mod #(.W(W)) u_mod_b (.mode_i(b_mod_i), .bus_i(b_i), .bus_o(b_m));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            a_q    <= '0;
            b_q    <= '0;
            cin_q  <= 1'b0;
            op_q   <= OP_MOVE;
        end else if (accept) begin
            busy_q <= 1'b1;
            a_q    <= a_m;
            b_q    <= b_m;
            cin_q  <= cin_i;
            op_q   <= op_d;
        end else if (done_o) begin
            busy_q <= 1'b0;
        end
    end

    rc_carry_chain #(.W(W)) u_chain (
        .clk        (clk),
        .rst        (rst),
        .load_i     (accept),
        .arith_i    (op_d == OP_ADD),
        .new_a_i    (a_m),
        .new_b_i    (b_m),
        .held_a_i   (a_q),
        .held_b_i   (b_q),
        .held_cin_i (cin_q),
        .known_o    (known),
        .sum_o      (sum),
        .cout_o     (chain_cout)
    );

    rc_completion #(.W(W)) u_done (.known_i(known), .all_o(complete));

    assign done_o = busy_q & complete;

    always_comb begin
        unique case (op_q)
            OP_AND:  res_o = a_q & b_q;
            OP_OR:   res_o = a_q | b_q;
            OP_XOR:  res_o = a_q ^ b_q;
            OP_ADD:  res_o = sum;
            default: res_o = a_q;
        endcase
    end

    assign cout_o = (op_q == OP_ADD) & chain_cout;
    assign zero_o = ~|res_o;

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    assert_logic_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && op_d != OP_ADD) |=> done_o);
    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (rst)
        (req_i && busy_q) |=> ($stable(a_q) && $stable(b_q) && $stable(op_q)));
    assert_hold_after_done_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !req_i) |=> $stable(res_o));

endmodule

// File: tb/sim_rc_alu.sv
module sim_rc_alu;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  am = '0, bm = '0;
    logic [31:0] a = '0, b = '0;
    logic        cin = 1'b0;
    logic        done, cout, zero;
    logic [31:0] res;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rc_alu u0 (
        .clk(clk), .rst(rst), .req_i(req), .op_i(op), .a_mod_i(am), .b_mod_i(bm),
        .a_i(a), .b_i(b), .cin_i(cin), .done_o(done), .res_o(res),
        .cout_o(cout), .zero_o(zero)
    );

    // vectors: A, B, op, A modifier, B modifier, carry-in
    localparam logic [31:0] VA [NV] = '{32'd5, 32'hffffffff, 32'hffffffff, 32'h12345678,
        32'h12345678, 32'h0000ffff, 32'hdeadbeef, 32'hdeadbeef, 32'd100, 32'h0000ffff,
        32'd0, 32'h80000000};
    localparam logic [31:0] VB [NV] = '{32'd3, 32'd1, 32'd0, 32'h0f0f0f0f,
        32'h0f0f0f0f, 32'h00ff00ff, 32'd7, 32'd7, 32'd58, 32'd9,
        32'd0, 32'h80000000};
    localparam logic [2:0] VOP [NV] = '{3'd4, 3'd4, 3'd4, 3'd1, 3'd2, 3'd3, 3'd0, 3'd0,
        3'd4, 3'd7, 3'd4, 3'd4};
    localparam logic [1:0] VAM [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd2,
        2'd0, 2'd1, 2'd3, 2'd0};
    localparam logic [1:0] VBM [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd0, 2'd0,
        2'd1, 2'd0, 2'd0, 2'd0};
    localparam logic VCI [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b1, 1'b0, 1'b0, 1'b0};

    function automatic logic [31:0] apply_mod(logic [1:0] m, logic [31:0] v);
        case (m)
            2'd1: return ~v;
            2'd2: return 32'd0;
            2'd3: return 32'hffffffff;
            default: return v;
        endcase
    endfunction

    function automatic logic [32:0] ref_calc(logic [2:0] o, logic [31:0] x, logic [31:0] y, logic c);
        case (o)
            3'd1: return {1'b0, x & y};
            3'd2: return {1'b0, x | y};
            3'd3: return {1'b0, x ^ y};
            3'd4: return {1'b0, x} + {1'b0, y} + {32'd0, c};
            default: return {1'b0, x};
        endcase
    endfunction

    function automatic int ref_lat(logic [2:0] o, logic [31:0] x, logic [31:0] y);
        int run = 0;
        int best = 0;
        if (o != 3'd4) return 1;
        for (int i = 0; i < 32; i++) begin
            if (x[i] ^ y[i]) begin
                run++;
                if (run > best) best = run;
            end else begin
                run = 0;
            end
        end
        return best + 1;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // issue one request at a falling edge and count cycles until done
    task automatic run_op(logic [2:0] o, logic [1:0] ma, logic [1:0] mb,
                          logic [31:0] x, logic [31:0] y, logic c, output int lat);
        @(negedge clk);
        req = 1'b1; op = o; am = ma; bm = mb; a = x; b = y; cin = c;
        @(negedge clk);
        req = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic verify(logic [2:0] o, logic [1:0] ma, logic [1:0] mb,
                          logic [31:0] x, logic [31:0] y, logic c, int lat, string tag);
        logic [31:0] xm, ym;
        logic [32:0] r;
        int el;
        xm = apply_mod(ma, x);
        ym = apply_mod(mb, y);
        r  = ref_calc(o, xm, ym, c);
        el = ref_lat(o, xm, ym);
        check(res == r[31:0], {tag, " R1 R2 R3 result"}, res, r[31:0]);
        check(cout == r[32], {tag, " R9 cout"}, {31'd0, cout}, {31'd0, r[32]});
        check(zero == (r[31:0] == 0), {tag, " R9 zero"}, {31'd0, zero}, {31'd0, r[31:0] == 0});
        check(lat == el, {tag, (o == 3'd4) ? " R5 latency" : " R6 latency"}, lat, el);
        @(negedge clk);
        check(done == 1'b0, {tag, " R7 done pulse"}, {31'd0, done}, 32'd0);
        check(res == r[31:0], {tag, " R7 result held"}, res, r[31:0]);
    endtask

    initial begin
        repeat (CLK_PERIOD * 150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(done == 1'b0, "R10 done after reset", {31'd0, done}, 32'd0);
        check(res == 32'd0, "R10 result after reset", res, 32'd0);
        check(zero == 1'b1, "R10 zero after reset", {31'd0, zero}, 32'd1);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(done == 1'b0, "R10 idle without request", {31'd0, done}, 32'd0);

        for (int k = 0; k < NV; k++) begin
            run_op(VOP[k], VAM[k], VBM[k], VA[k], VB[k], VCI[k], lat);
            verify(VOP[k], VAM[k], VBM[k], VA[k], VB[k], VCI[k], lat, $sformatf("vec%0d", k));
        end

        // R8: second request in the middle of a 33-cycle add is ignored
        @(negedge clk);
        req = 1'b1; op = 3'd4; am = 2'd0; bm = 2'd0; a = 32'hffffffff; b = 32'd0; cin = 1'b1;
        @(negedge clk);
        req = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            if (lat == 3) begin
                req = 1'b1; op = 3'd0; a = 32'h00000001; b = 32'h1; cin = 1'b0;
            end else begin
                req = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        req = 1'b0;
        check(lat == 33, "R8 latency unchanged by ignored request", lat, 33);
        check(res == 32'd0, "R8 result unchanged by ignored request", res, 32'd0);
        check(cout == 1'b1, "R8 cout unchanged by ignored request", {31'd0, cout}, 32'd1);
        check(zero == 1'b1, "R8 zero flag", {31'd0, zero}, 32'd1);
        @(negedge clk);

        // R7: long idle after an operation keeps outputs
        run_op(3'd3, 2'd0, 2'd0, 32'hf0f0f0f0, 32'h0ff00ff0, 1'b0, lat);
        repeat (5) @(negedge clk);
        check(res == 32'hff00ff00, "R7 result held while idle", res, 32'hff00ff00);
        check(done == 1'b0, "R7 no done while idle", {31'd0, done}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule